// File: doc/BRIEF.md
# Memory ECC Error Logger

This block sits beside a memory datapath and records the ECC and other error events that the datapath reports. Each event class has its own strobe. A strobe sets a sticky status flag. For correctable (single-bit) and uncorrectable (multi-bit) ECC events, the block also captures the failing line address, the channel number and the 8-bit syndrome. Software reads the captured information through a small register port. It clears flags by writing ones to them.

Only one set of error information is held at a time. An uncorrectable error takes priority over a correctable one, and a correctable error never displaces uncorrectable information. The capture registers become free again once every status flag is clear. A command register selects which event classes raise a one-cycle system-error pulse when their flag first becomes set.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, every register reads zero and `sysErrPulse` is low.
- R2: The status register is read at `regSel` 0. Events set these bits:
  - single-bit ECC error sets bit 0
  - multi-bit ECC error sets bit 1
  - refresh timeout sets bit 8
  - lock to non-memory space sets bit 9
  - thermal event sets bit 11

  All other status bits read zero, and `regSel` codes 5 to 7 read zero.
- R3: A write to `regSel` 0 clears each status bit of mask 0x0B03 that is written 1. Bits written 0 keep their value.
- R4: The address register is read at `regSel` 2. It returns:
  - line address bits 31:7 in bits 31:7
  - the channel in bit 0
  - zero in bits 6:1

  The extension register is read at `regSel` 3. It returns address bit 32 in bit 0, with its other bits zero.
- R5: The syndrome register is read at `regSel` 4. It returns the 8-bit syndrome of the captured error in bits 7:0.
- R6: A multi-bit error arriving while correctable information is held replaces the address, channel and syndrome. Both flags 0 and 1 then read set.
- R7: While uncorrectable information is held, a single-bit error sets bit 0 but leaves the captured address, channel and syndrome unchanged.
- R8: While correctable information is held, a further single-bit error does not change the captured data. Once all status bits are clear, the next error of either class is captured.
- R9: The command register is read and written at `regSel` 1, with writable bits limited to mask 0x0B03. An event whose command bit is set and whose status bit was 0 drives `sysErrPulse` high for exactly the one cycle after the event is sampled.
- R10: No pulse is raised for an event whose command bit is clear, nor for an event whose status bit is already set.
- R11: If a clearing write and a new event hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbeStrobe | input | 1 | Single-bit (correctable) ECC error event |
| mbeStrobe | input | 1 | Multi-bit (uncorrectable) ECC error event |
| refreshToStrobe | input | 1 | Refresh timeout event |
| lockStrobe | input | 1 | Locked access to non-memory space event |
| thermStrobe | input | 1 | Thermal sensor event |
| errLineAddr | input | 26 | Failing address bits 32:7 |
| errChan | input | 1 | Channel of the failing access |
| errSyn | input | 8 | ECC syndrome of the failing access |
| regSel | input | 3 | Register select for read and write |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 16 | Write data |
| regRdData | output | 32 | Combinational read data of the selected register |
| sysErrPulse | output | 1 | One-cycle system-error pulse |

## Verification
The assertions assume that address, channel and syndrome are valid in the same cycle as an ECC strobe. They also assume that `regWrEn` is sampled only at clock edges, so a clearing write and an event each take effect in exactly one cycle.

The stimulus drives every strobe and write for a single cycle, changing inputs just after a rising edge. It holds the register select steady while it reads, and it only places coincident clear and event cycles where the R11 check wants them.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam int STAT_W = 16;

  localparam int BIT_SBE   = 0;
  localparam int BIT_MBE   = 1;
  localparam int BIT_REFTO = 8;
  localparam int BIT_LOCK  = 9;
  localparam int BIT_THERM = 11;

  localparam logic [STAT_W-1:0] ERR_MASK = 16'h0B03;

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_CE   = 2'd1,
    HOLD_UE   = 2'd2
  } holdClass_e;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CMD    = 3'd1,
    SEL_ADDR   = 3'd2,
    SEL_EXT    = 3'd3,
    SEL_SYN    = 3'd4
  } regSel_e;

  typedef struct packed {
    logic captureEn;
  } dpStrobes_t;

endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evtVec,
  input  logic              wrStatus,
  input  logic              wrCmd,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] cmdQ,
  output logic              sysErr,
  output dpStrobes_t        strobes
);

  holdClass_e        classQ, classNext, baseClass;
  logic [STAT_W-1:0] clrMask, cleared, nextStatus, keepMask;
  logic              captureNext;

  always_comb begin
    clrMask    = wrStatus ? (wrData & ERR_MASK) : '0;
    cleared    = statusQ & ~clrMask;
    nextStatus = (cleared | evtVec) & ERR_MASK;
    baseClass  = (cleared == '0) ? HOLD_NONE : classQ;
    classNext   = baseClass;
    captureNext = 1'b0;
    if (evtVec[BIT_MBE] && baseClass != HOLD_UE) begin
      classNext   = HOLD_UE;
      captureNext = 1'b1;
    end else if (evtVec[BIT_SBE] && baseClass == HOLD_NONE) begin
      classNext   = HOLD_CE;
      captureNext = 1'b1;
    end
  end

  assign strobes.captureEn = captureNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ <= '0;
      cmdQ    <= '0;
      classQ  <= HOLD_NONE;
      sysErr  <= 1'b0;
    end else begin
      statusQ <= nextStatus;
      classQ  <= classNext;
      sysErr  <= |(nextStatus & ~statusQ & cmdQ);
      if (wrCmd) cmdQ <= wrData & ERR_MASK;
    end
  end

  assign keepMask = statusQ & ~(wrStatus ? wrData : '0);

  assert_sbe_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evtVec[BIT_SBE] |=> statusQ[BIT_SBE]);

  assert_mbe_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evtVec[BIT_MBE] |=> statusQ[BIT_MBE]);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (keepMask != '0) |=> ((statusQ & $past(keepMask)) == $past(keepMask)));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evtVec & cmdQ & ~statusQ & ERR_MASK)) |=> sysErr);

  assert_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(evtVec & cmdQ)) |=> !sysErr);

  assert_clear_race_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStatus && wrData[BIT_SBE] && evtVec[BIT_SBE]) |=> statusQ[BIT_SBE]);

endmodule

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 33,
  parameter int GRAIN_BITS = 7,
  parameter int SYN_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dpStrobes_t                 strobes,
  input  logic [ADDR_W-1:GRAIN_BITS] errLineAddr,
  input  logic                       errChan,
  input  logic [SYN_W-1:0]           errSyn,
  input  logic [2:0]                 regSel,
  input  logic [STAT_W-1:0]          statusQ,
  input  logic [STAT_W-1:0]          cmdQ,
  output logic [31:0]                rdData
);

  localparam int EXT_W = ADDR_W - 32;
  localparam int LOW_W = GRAIN_BITS - 1;

  logic [31:GRAIN_BITS] addrQ;
  logic [EXT_W-1:0]     extQ;
  logic                 chanQ;
  logic [SYN_W-1:0]     synQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ <= '0;
      extQ  <= '0;
      chanQ <= 1'b0;
      synQ  <= '0;
    end else if (strobes.captureEn) begin
      addrQ <= errLineAddr[31:GRAIN_BITS];
      extQ  <= errLineAddr[ADDR_W-1:32];
      chanQ <= errChan;
      synQ  <= errSyn;
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_STATUS: rdData = {16'h0, statusQ};
      SEL_CMD:    rdData = {16'h0, cmdQ};
      SEL_ADDR:   rdData = {addrQ, {LOW_W{1'b0}}, chanQ};
      SEL_EXT:    rdData = {{(32-EXT_W){1'b0}}, extQ};
      SEL_SYN:    rdData = {{(32-SYN_W){1'b0}}, synQ};
      default:    rdData = '0;
    endcase
  end

  assert_hold_info_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.captureEn |=> ($stable(addrQ) && $stable(chanQ) && $stable(synQ) && $stable(extQ)));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.captureEn |=> (synQ == $past(errSyn)));

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 33,
  parameter int GRAIN_BITS = 7,
  parameter int SYN_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sbeStrobe,
  input  logic                       mbeStrobe,
  input  logic                       refreshToStrobe,
  input  logic                       lockStrobe,
  input  logic                       thermStrobe,
  input  logic [ADDR_W-1:GRAIN_BITS] errLineAddr,
  input  logic                       errChan,
  input  logic [SYN_W-1:0]           errSyn,
  input  logic [2:0]                 regSel,
  input  logic                       regWrEn,
  input  logic [STAT_W-1:0]          regWrData,
  output logic [31:0]                regRdData,
  output logic                       sysErrPulse
);

  logic [STAT_W-1:0] evtVec, statusQ, cmdQ;
  logic              wrStatus, wrCmd;
  dpStrobes_t        strobes;

  always_comb begin
    evtVec            = '0;
    evtVec[BIT_SBE]   = sbeStrobe;
    evtVec[BIT_MBE]   = mbeStrobe;
    evtVec[BIT_REFTO] = refreshToStrobe;
    evtVec[BIT_LOCK]  = lockStrobe;
    evtVec[BIT_THERM] = thermStrobe;
  end

  assign wrStatus = regWrEn && (regSel == SEL_STATUS);
  assign wrCmd    = regWrEn && (regSel == SEL_CMD);

  ecc_log_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .evtVec   (evtVec),
    .wrStatus (wrStatus),
    .wrCmd    (wrCmd),
    .wrData   (regWrData),
    .statusQ  (statusQ),
    .cmdQ     (cmdQ),
    .sysErr   (sysErrPulse),
    .strobes  (strobes)
  );

  ecc_log_dp #(
    .ADDR_W     (ADDR_W),
    .GRAIN_BITS (GRAIN_BITS),
    .SYN_W      (SYN_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .errLineAddr (errLineAddr),
    .errChan     (errChan),
    .errSyn      (errSyn),
    .regSel      (regSel),
    .statusQ     (statusQ),
    .cmdQ        (cmdQ),
    .rdData      (regRdData)
  );

endmodule

// File: tb/ecc_err_logger_bench.sv
`timescale 1ns/1ps
module ecc_err_logger_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbeStrobe = 1'b0, mbeStrobe = 1'b0, refreshToStrobe = 1'b0;
  logic        lockStrobe = 1'b0, thermStrobe = 1'b0;
  logic [32:7] errLineAddr = '0;
  logic        errChan = 1'b0;
  logic [7:0]  errSyn = '0;
  logic [2:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sysErrPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;

  always #2 clk = ~clk;

  ecc_err_logger u_ecc_err_logger (
    .clk(clk), .rst_n(rst_n),
    .sbeStrobe(sbeStrobe), .mbeStrobe(mbeStrobe),
    .refreshToStrobe(refreshToStrobe), .lockStrobe(lockStrobe),
    .thermStrobe(thermStrobe), .errLineAddr(errLineAddr),
    .errChan(errChan), .errSyn(errSyn), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sysErrPulse(sysErrPulse)
  );

  // monitor: compares the read port against queued expectations
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checks++;
      if (regRdData !== cur.exp) begin
        fails++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", cur.tag, regRdData, cur.exp);
      end
    end
  end

  task automatic checkReg(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    regSel = sel;
    it.exp = exp;
    it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic checkPulse(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (sysErrPulse !== exp) begin
      fails++;
      $display("FAIL %s: sysErrPulse got %0b expected %0b", tag, sysErrPulse, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [15:0] data);
    @(posedge clk); #1;
    regSel = sel; regWrData = data; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  // which: {therm, lock, refresh, mbe, sbe}
  task automatic event1(input logic [4:0] which, input logic [32:0] a,
                        input logic ch, input logic [7:0] syn);
    @(posedge clk); #1;
    {thermStrobe, lockStrobe, refreshToStrobe, mbeStrobe, sbeStrobe} = which;
    errLineAddr = a[32:7]; errChan = ch; errSyn = syn;
    @(posedge clk); #1;
    {thermStrobe, lockStrobe, refreshToStrobe, mbeStrobe, sbeStrobe} = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    checkPulse(1'b0, "R1 pulse after reset");
    for (int s = 0; s < 5; s++) checkReg(s[2:0], 32'h0, "R1 reset register");
    checkReg(3'd5, 32'h0, "R2 unmapped select");

    // R4 R5 first correctable capture
    event1(5'b00001, 33'h1_2345_67FF, 1'b1, 8'h5A);
    checkPulse(1'b0, "R10 disabled CE no pulse");
    checkReg(3'd0, 32'h0000_0001, "R2 CE status bit");
    checkReg(3'd2, 32'h2345_6781, "R4 address and channel");
    checkReg(3'd3, 32'h0000_0001, "R4 extension bit 32");
    checkReg(3'd4, 32'h0000_005A, "R5 syndrome");

    // R8 second CE does not overwrite
    event1(5'b00001, 33'h0_0000_1000, 1'b0, 8'h11);
    checkReg(3'd2, 32'h2345_6781, "R8 CE held address");
    checkReg(3'd4, 32'h0000_005A, "R8 CE held syndrome");

    // R6 UE overwrites CE
    event1(5'b00010, 33'h0_ABCD_EF00, 1'b0, 8'hC3);
    checkReg(3'd0, 32'h0000_0003, "R6 both flags");
    checkReg(3'd2, 32'hABCD_EF00, "R6 UE address");
    checkReg(3'd3, 32'h0000_0000, "R6 UE extension");
    checkReg(3'd4, 32'h0000_00C3, "R6 UE syndrome");

    // R7 CE while UE held
    event1(5'b00001, 33'h1_FFFF_FFFF, 1'b1, 8'h77);
    checkReg(3'd2, 32'hABCD_EF00, "R7 address kept");
    checkReg(3'd4, 32'h0000_00C3, "R7 syndrome kept");
    checkReg(3'd3, 32'h0000_0000, "R7 extension kept");

    // R3 write-1-to-clear
    regWrite(3'd0, 16'h0001);
    checkReg(3'd0, 32'h0000_0002, "R3 clear bit 0 only");
    regWrite(3'd0, 16'h0000);
    checkReg(3'd0, 32'h0000_0002, "R3 write zero no effect");
    regWrite(3'd0, 16'hFFFF);
    checkReg(3'd0, 32'h0000_0000, "R3 clear all");

    // R8 new capture after all clear
    event1(5'b00001, 33'h0_1357_9BDF, 1'b1, 8'h3C);
    checkReg(3'd2, 32'h1357_9B81, "R8 recapture address");
    checkReg(3'd4, 32'h0000_003C, "R8 recapture syndrome");

    // R2 other event classes
    event1(5'b11100, 33'h0, 1'b0, 8'h00);
    checkReg(3'd0, 32'h0000_0B01, "R2 refresh lock thermal bits");
    regWrite(3'd0, 16'hFFFF);

    // R9 command register and pulse
    regWrite(3'd1, 16'hFFFF);
    checkReg(3'd1, 32'h0000_0B03, "R9 command mask");
    event1(5'b00001, 33'h0, 1'b0, 8'h01);
    checkPulse(1'b1, "R9 pulse on enabled CE");
    checkPulse(1'b0, "R9 pulse lasts one cycle");
    event1(5'b00001, 33'h0, 1'b0, 8'h02);
    checkPulse(1'b0, "R10 no pulse when bit already set");
    regWrite(3'd1, 16'h0100);
    regWrite(3'd0, 16'hFFFF);
    event1(5'b10000, 33'h0, 1'b0, 8'h00);
    checkPulse(1'b0, "R10 thermal disabled");
    event1(5'b00100, 33'h0, 1'b0, 8'h00);
    checkPulse(1'b1, "R9 refresh enabled pulse");
    checkReg(3'd0, 32'h0000_0900, "R2 thermal and refresh flags");

    // R11 clear and event in the same cycle
    regWrite(3'd0, 16'hFFFF);
    event1(5'b00001, 33'h0, 1'b0, 8'h09);
    @(posedge clk); #1;
    regSel = 3'd0; regWrData = 16'h0001; regWrEn = 1'b1; sbeStrobe = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0; sbeStrobe = 1'b0;
    checkReg(3'd0, 32'h0000_0001, "R11 event wins over clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule